// File: doc/BRIEF.md
# Key-Locked Inter-Processor Mailbox

This block gives a local processor a set of mailbox channels for posting fixed-size messages to a remote processor over a simple word-wide register bus. Each channel has its own 64-byte register window. An owner claims an idle channel by writing its one-hot acknowledge vector to the channel's owner register. It then sets a destination interrupt vector and a mask, fills eight data words and fires the send trigger. The channel raises the unmasked destination interrupt bits while the message is in flight. When the acknowledge arrives, it raises the owner's acknowledge bit.

A global key register protects every channel write. Writing the key value opens the gate, and writing any other value closes it. Reads are always allowed. Each channel runs its own state machine: IDLE, OWNED (claimed), READY (after a finished exchange), BUSY (in flight) and ACKED. The transitions are:
- claim: IDLE→OWNED
- send: OWNED/READY→BUSY
- ack: BUSY→ACKED, either on a timer in automatic mode or on a remote-side clear in manual mode
- clear: ACKED→READY
- release: any→IDLE

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the key gate is closed, so reading address 0xA00 returns 1. Every channel is IDLE: mode reads 0x10 and the owner register reads 0. The mask reads 0xFFFFFFFF, and both interrupt outputs are 0.
- R2: A write of 0x1ACCE551 to 0xA00 opens the gate, and 0xA00 then reads 0. A write of any other value closes it, and 0xA00 then reads 1.
- R3: While the gate is closed, writes to channel registers change nothing. Reads of channel registers still return their contents.
- R4: Writing a one-hot value to the owner register (window offset 0x00) of an IDLE channel stores it, and the channel becomes OWNED. A non-one-hot nonzero value, or a claim of a non-IDLE channel, is ignored.
- R5: Mode register (offset 0x10) readback uses these bits:
  - bit 4: IDLE
  - bit 5: OWNED or READY
  - bit 6: BUSY
  - bit 7: ACKED
  - bit 0: automatic-acknowledge select, written through bit 0 of the same register
- R6: Writing a value equal to the owner register to the send register (offset 0x1C) in OWNED or READY enters BUSY. While BUSY, dst_irq_o and the pending-status register (offset 0x0C) both equal the destination register (offset 0x04) with the mask register (offset 0x14) bits removed. A send with any other value, or a send to an IDLE channel, is ignored.
- R7: In automatic mode the channel stays BUSY through 3 edges after the send edge. It becomes ACKED on the 4th edge, and ack_irq_o then equals the owner register while dst_irq_o drops.
- R8: In manual mode (bit 0 clear) BUSY persists until the interrupt clear register (offset 0x18) is written with a value equal to the destination register. That write moves the channel to ACKED.
- R9: In ACKED, writing a value equal to the owner register to offset 0x18 returns the channel to READY and drops ack_irq_o. Any other value is ignored.
- R10: Writing 0 to the owner register releases the channel to IDLE from any state and zeroes its data words. If that write lands on the edge where the automatic timer expires, the release wins.
- R11: Eight data words sit at offsets 0x20 to 0x3C. Writes to them are ignored while BUSY. Any write to offset 0x08 outside BUSY zeroes all eight.
- R12: Channel n's window starts at byte address n×0x40, and writes to one channel leave every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_rd_i | input | 1 | Read strobe; data appears on bus_rdata_o after the next edge |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| dst_irq_o | output | 32 | OR over channels of unmasked destination bits of BUSY channels |
| ack_irq_o | output | 32 | OR over channels of owner bits of ACKED channels |

## Verification
The automatic-acknowledge timer expiry and the owner's release write can land on the same clock edge of one channel. The bench provokes this by firing a send in automatic mode, idling exactly three cycles, and then writing 0 to the owner register so the write is sampled on the fourth edge. The collision is judged correct when the mode register reads 0x11 (IDLE with automatic mode kept) rather than 0x81. The acknowledge output must also stay at zero and the data words must read back as zero.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [2:0] {
        CH_IDLE  = 3'd0,
        CH_OWNED = 3'd1,
        CH_READY = 3'd2,
        CH_BUSY  = 3'd3,
        CH_ACKED = 3'd4
    } ch_state_e;

    // word offsets inside a channel window
    localparam int OFF_SRC   = 0;
    localparam int OFF_DST   = 1;
    localparam int OFF_DCLR  = 2;
    localparam int OFF_DSTAT = 3;
    localparam int OFF_MODE  = 4;
    localparam int OFF_MASK  = 5;
    localparam int OFF_ICLR  = 6;
    localparam int OFF_SEND  = 7;
    localparam int OFF_DATA  = 8;

    // mode register bit positions
    localparam int MODE_AUTO_BIT = 0;
    localparam int MODE_IDLE_BIT = 4;
    localparam int MODE_RDY_BIT  = 5;
    localparam int MODE_BUSY_BIT = 6;
    localparam int MODE_ACK_BIT  = 7;

endpackage

// File: rtl/mbox_lock.sv
module mbox_lock #(
    parameter int          DW  = 32,
    parameter logic [31:0] KEY = 32'h1ACC_E551
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          open_o,
    output logic [DW-1:0] rdata_o
);

    logic open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (wr_i) begin
            open_q <= (wdata_i == DW'(KEY));
        end
    end

    always_comb begin
        open_o  = open_q;
        rdata_o = open_q ? '0 : DW'(1);
    end

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i == DW'(KEY)) |=> (rdata_o == '0)); // R2

    AST_BADKEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i != DW'(KEY)) |=> !open_o); // R2

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(open_q)); // R2

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
    import mbox_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MSG_WORDS = 8,
    parameter int ACK_DELAY = 4,
    parameter int OFF_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             lock_open_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic [DW-1:0]    dst_irq_o,
    output logic [DW-1:0]    ack_irq_o
);

    localparam int CNT_W = $clog2(ACK_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 1);

    ch_state_e      st_q, st_d;
    logic [DW-1:0]  src_q, dst_q, mask_q;
    logic           auto_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]  data_q [MSG_WORDS];

    logic wr, wr_src, wr_dst, wr_dclr, wr_mode, wr_mask, wr_iclr, wr_send;
    logic do_claim, do_release, go_busy, auto_done, busy;
    logic [MSG_WORDS-1:0] wr_data;

    function automatic logic onehot(input logic [DW-1:0] v);
        return (v != '0) && ((v & (v - DW'(1))) == '0);
    endfunction

    // write decode
    always_comb begin
        wr      = sel_i && lock_open_i;
        wr_src  = wr && (off_i == OFF_W'(OFF_SRC));
        wr_dst  = wr && (off_i == OFF_W'(OFF_DST));
        wr_dclr = wr && (off_i == OFF_W'(OFF_DCLR));
        wr_mode = wr && (off_i == OFF_W'(OFF_MODE));
        wr_mask = wr && (off_i == OFF_W'(OFF_MASK));
        wr_iclr = wr && (off_i == OFF_W'(OFF_ICLR));
        wr_send = wr && (off_i == OFF_W'(OFF_SEND));
        for (int i = 0; i < MSG_WORDS; i++) begin
            wr_data[i] = wr && (off_i == OFF_W'(OFF_DATA + i));
        end
        busy       = (st_q == CH_BUSY);
        do_release = wr_src && (wdata_i == '0);
        do_claim   = wr_src && (st_q == CH_IDLE) && onehot(wdata_i);
        go_busy    = wr_send && (wdata_i == src_q) &&
                     ((st_q == CH_OWNED) || (st_q == CH_READY));
        auto_done  = auto_q && (cnt_q == CNT_LAST);
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (do_release) begin
            st_d = CH_IDLE;
        end else begin
            unique case (st_q)
                CH_IDLE:  if (do_claim) st_d = CH_OWNED;
                CH_OWNED,
                CH_READY: if (go_busy) st_d = CH_BUSY;
                CH_BUSY:  if (auto_done ||
                              (!auto_q && wr_iclr && dst_q != '0 && wdata_i == dst_q))
                              st_d = CH_ACKED;
                CH_ACKED: if (wr_iclr && wdata_i == src_q) st_d = CH_READY;
                default:  st_d = CH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            mask_q <= '1;
            auto_q <= 1'b0;
            cnt_q  <= '0;
            for (int i = 0; i < MSG_WORDS; i++) data_q[i] <= '0;
        end else begin
            if (go_busy)                        cnt_q <= '0;
            else if (busy && cnt_q != CNT_LAST) cnt_q <= cnt_q + CNT_W'(1);
            if (do_release)    src_q <= '0;
            else if (do_claim) src_q <= wdata_i;
            if (wr_dst)  dst_q  <= wdata_i;
            if (wr_mask) mask_q <= wdata_i;
            if (wr_mode) auto_q <= wdata_i[MODE_AUTO_BIT];
            for (int i = 0; i < MSG_WORDS; i++) begin
                if (do_release || (wr_dclr && !busy)) data_q[i] <= '0;
                else if (wr_data[i] && !busy)         data_q[i] <= wdata_i;
            end
        end
    end

    // outputs
    always_comb begin
        dst_irq_o = busy ? (dst_q & ~mask_q) : '0;
        ack_irq_o = (st_q == CH_ACKED) ? src_q : '0;
        rdata_o   = '0;
        if (off_i == OFF_W'(OFF_SRC))   rdata_o = src_q;
        if (off_i == OFF_W'(OFF_DST))   rdata_o = dst_q;
        if (off_i == OFF_W'(OFF_DSTAT)) rdata_o = dst_irq_o;
        if (off_i == OFF_W'(OFF_MASK))  rdata_o = mask_q;
        if (off_i == OFF_W'(OFF_MODE)) begin
            rdata_o[MODE_AUTO_BIT] = auto_q;
            rdata_o[MODE_IDLE_BIT] = (st_q == CH_IDLE);
            rdata_o[MODE_RDY_BIT]  = (st_q == CH_OWNED) || (st_q == CH_READY);
            rdata_o[MODE_BUSY_BIT] = busy;
            rdata_o[MODE_ACK_BIT]  = (st_q == CH_ACKED);
        end
        for (int i = 0; i < MSG_WORDS; i++) begin
            if (off_i == OFF_W'(OFF_DATA + i)) rdata_o = data_q[i];
        end
    end

    AST_LOCKED_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !lock_open_i) |=> $stable(src_q)); // R3

    AST_IDLE_NO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_IDLE) |-> (src_q == '0)); // R10

    AST_ACK_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_ACKED && $past(st_q) != CH_ACKED) |-> ($past(st_q) == CH_BUSY)); // R7

    AST_AUTO_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && auto_q && cnt_q == CNT_LAST && !do_release) |=> (st_q == CH_ACKED)); // R7

    AST_BUSY_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !do_release) |=> $stable(data_q[0])); // R11

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbox_pkg::*;
#(
    parameter int          NUM_CH    = 32,
    parameter int          DW        = 32,
    parameter int          ADDR_W    = 12,
    parameter int          MSG_WORDS = 8,
    parameter int          ACK_DELAY = 4,
    parameter logic [11:0] LOCK_ADDR = 12'hA00,
    parameter logic [31:0] LOCK_KEY  = 32'h1ACC_E551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic [DW-1:0]     dst_irq_o,
    output logic [DW-1:0]     ack_irq_o
);

    localparam int OFF_W = $clog2(OFF_DATA + MSG_WORDS);
    localparam int CHF_W = ADDR_W - OFF_W - 2;

    logic [OFF_W-1:0] off;
    logic [CHF_W-1:0] ch_idx;
    logic             ch_hit, lock_hit, lock_open;
    logic [DW-1:0]    lock_rd, ch_rd_sel, rd_next;
    logic [DW-1:0]    ch_rd  [NUM_CH];
    logic [DW-1:0]    ch_dst [NUM_CH];
    logic [DW-1:0]    ch_ack [NUM_CH];
    logic [DW-1:0]    rdata_q;
    logic             unused_addr_bits;

    assign off              = bus_addr_i[OFF_W+1:2];
    assign ch_idx           = bus_addr_i[ADDR_W-1:OFF_W+2];
    assign unused_addr_bits = ^bus_addr_i[1:0];
    assign lock_hit         = (bus_addr_i == ADDR_W'(LOCK_ADDR));
    assign ch_hit           = (ch_idx < CHF_W'(NUM_CH));

    mbox_lock #(.DW(DW), .KEY(LOCK_KEY)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i && lock_hit),
        .wdata_i (bus_wdata_i),
        .open_o  (lock_open),
        .rdata_o (lock_rd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mbox_channel #(
            .DW(DW), .MSG_WORDS(MSG_WORDS), .ACK_DELAY(ACK_DELAY), .OFF_W(OFF_W)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel_i       (bus_wr_i && ch_hit && ch_idx == CHF_W'(g)),
            .lock_open_i (lock_open),
            .off_i       (off),
            .wdata_i     (bus_wdata_i),
            .rdata_o     (ch_rd[g]),
            .dst_irq_o   (ch_dst[g]),
            .ack_irq_o   (ch_ack[g])
        );
    end

    always_comb begin
        ch_rd_sel = '0;
        dst_irq_o = '0;
        ack_irq_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CHF_W'(i)) ch_rd_sel = ch_rd[i];
            dst_irq_o = dst_irq_o | ch_dst[i];
            ack_irq_o = ack_irq_o | ch_ack[i];
        end
        if (lock_hit)    rd_next = lock_rd;
        else if (ch_hit) rd_next = ch_rd_sel;
        else             rd_next = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_next;
    end

    assign bus_rdata_o = rdata_q;

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o)); // R3

endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata, dst_irq, ack_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic rd_seen = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipc_mailbox i_ipc_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .dst_irq_o(dst_irq), .ack_irq_o(ack_irq)
    );

    // monitor: compare each read result against the scoreboard queue
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read data act=%h exp=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // reset state
        rd(12'hA00, 32'h1, "R1 gate closed");
        rd(12'h010, 32'h10, "R1 ch0 idle");
        rd(12'h0C0, 32'h0, "R1 ch3 owner");
        rd(12'h0D4, 32'hFFFF_FFFF, "R1 ch3 mask");
        chk(dst_irq, 32'h0, "R1 dst irq");
        chk(ack_irq, 32'h0, "R1 ack irq");

        // locked writes ignored
        wr(12'h0C0, 32'h4);
        rd(12'h0C0, 32'h0, "R3 locked claim ignored");
        rd(12'h0D0, 32'h10, "R3 mode readable while locked");

        // gate
        wr(12'hA00, 32'h1234_5678);
        rd(12'hA00, 32'h1, "R2 wrong key");
        wr(12'hA00, 32'h1ACC_E551);
        rd(12'hA00, 32'h0, "R2 key opens");

        // claim
        wr(12'h0C0, 32'h3);
        rd(12'h0C0, 32'h0, "R4 non-onehot claim");
        wr(12'h0C0, 32'h4);
        rd(12'h0C0, 32'h4, "R4 claim");
        rd(12'h0D0, 32'h20, "R5 owned ready bit");
        wr(12'h0C0, 32'h8);
        rd(12'h0C0, 32'h4, "R4 second claim ignored");

        // send on unclaimed channel 5
        wr(12'h15C, 32'h4);
        rd(12'h150, 32'h10, "R6 send to idle ignored");
        chk(dst_irq, 32'h0, "R6 no irq from idle send");

        // configure channel 3
        wr(12'h0C4, 32'h100);
        wr(12'h0D4, ~32'h100);
        wr(12'h0D0, 32'h1);
        for (int i = 0; i < 8; i++) wr(12'h0E0 + 12'(4*i), 32'hA0 + 32'(i));
        for (int i = 0; i < 8; i++) rd(12'h0E0 + 12'(4*i), 32'hA0 + 32'(i), "R11 data word");
        rd(12'h0D0, 32'h21, "R5 auto bit");

        wr(12'h0DC, 32'h8);
        rd(12'h0D0, 32'h21, "R6 mismatched send ignored");

        // automatic acknowledge timing
        wr(12'h0DC, 32'h4);
        chk(dst_irq, 32'h100, "R6 dst irq while busy");
        chk(ack_irq, 32'h0, "R7 no ack at send");
        rd(12'h0CC, 32'h100, "R6 pending status");
        wr(12'h0E0, 32'hDEAD);
        chk(ack_irq, 32'h0, "R7 no ack after edge 2");
        idle(1);
        chk(ack_irq, 32'h0, "R7 no ack after edge 3");
        idle(1);
        chk(ack_irq, 32'h4, "R7 ack after edge 4");
        chk(dst_irq, 32'h0, "R7 dst drops at ack");
        rd(12'h0E0, 32'hA0, "R11 busy write ignored");
        rd(12'h0D0, 32'h81, "R5 acked bit");

        // clear acknowledge
        wr(12'h0D8, 32'h8);
        chk(ack_irq, 32'h4, "R9 wrong clear ignored");
        wr(12'h0D8, 32'h4);
        chk(ack_irq, 32'h0, "R9 ack cleared");
        rd(12'h0D0, 32'h21, "R9 back to ready");

        // manual acknowledge
        wr(12'h0D0, 32'h0);
        wr(12'h0DC, 32'h4);
        idle(6);
        rd(12'h0D0, 32'h40, "R8 manual stays busy");
        chk(ack_irq, 32'h0, "R8 no ack in manual");
        wr(12'h0D8, 32'h100);
        chk(ack_irq, 32'h4, "R8 remote clear acks");
        rd(12'h0D0, 32'h80, "R8 acked");
        wr(12'h0D8, 32'h4);
        rd(12'h0D0, 32'h20, "R9 ready after manual");

        // release colliding with timer expiry
        wr(12'h0D0, 32'h1);
        wr(12'h0DC, 32'h4);
        idle(3);
        wr(12'h0C0, 32'h0);
        chk(ack_irq, 32'h0, "R10 release beats timer ack");
        chk(dst_irq, 32'h0, "R10 dst cleared");
        rd(12'h0D0, 32'h11, "R10 idle after collision");
        rd(12'h0C0, 32'h0, "R10 owner cleared");
        rd(12'h0E0, 32'h0, "R10 data zeroed");

        // channel independence and data clear
        wr(12'h1C0, 32'h2);
        wr(12'h1E0, 32'h55);
        rd(12'h1E0, 32'h55, "R12 ch7 data");
        rd(12'h1C0, 32'h2, "R12 ch7 owner");
        rd(12'h0E0, 32'h0, "R12 ch3 untouched");
        rd(12'h0D0, 32'h11, "R12 ch3 mode untouched");
        wr(12'h1C8, 32'h1);
        rd(12'h1E0, 32'h0, "R11 data clear");

        // close gate again
        wr(12'hA00, 32'h0);
        rd(12'hA00, 32'h1, "R2 gate reclosed");
        wr(12'h1C0, 32'h0);
        rd(12'h1C0, 32'h2, "R3 locked release ignored");

        idle(2);
        chk(32'(exp_q.size()), 32'h0, "R1 scoreboard drained");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule